// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritisation

This block decides which interrupt one channel of a FIFO-equipped serial port reports. It takes five raw conditions: a receiver line error, receive data available (derived here from the receive FIFO fill count and a selectable trigger threshold), a receive character timeout, transmit holding register empty, and a modem status change. It reduces them to a single status byte and an active-high interrupt line.

Exactly one source is reported at a time, chosen by a fixed four-level priority. Receive data and receive timeout share the second level, and data is preferred over timeout inside that level. A read of the status byte freezes the byte for the whole read. If the frozen byte reports transmit-empty, the read acknowledges that source. Every other source is level-driven and is sampled again on every cycle, so it stays reported until the surrounding logic clears its flag.

The control is a two-state machine. In `ST_TRACK` the status register loads the live encoding on every clock edge. The transition `TRACK->READ` is taken on a clock edge where the read strobe is high: the live byte is captured and, when it reports transmit-empty, that source is acknowledged. In `ST_READ` the byte holds while the strobe stays high (`READ->READ`). The transition `READ->TRACK` is taken when the strobe drops, and the live byte is loaded on that same edge. The receive trigger-level select is registered, and its reset value selects a 1-byte threshold.

Top module: `uirq_ident`

## Requirements
- R1: While reset is asserted, status reads 8'h01 and irq is 0. Every pending flag is cleared and the trigger threshold is 1 byte.
- R2: Status bit 0 is low exactly when an interrupt is pending, and irq is always the inverse of status bit 0.
- R3: A line error has the highest priority and is reported in status bits 3:1 as code 3'b011.
- R4: Receive data available (code 3'b010) outranks receive timeout (code 3'b110), and both outrank transmit-empty and modem status.
- R5: Transmit-empty (code 3'b001) outranks modem status (code 3'b000).
- R6: Status bits 7:6 read 2'b11 when the FIFO enable is set and 2'b00 when it is clear. Bits 5:4 always read 0.
- R7: With the FIFO enabled, trigger select values 0, 1, 2 and 3 give thresholds of 1, 4, 8 and 14 bytes. Receive data is pending when the fill count is at or above the threshold.
- R8: With the FIFO disabled, receive data is pending when the count is at least 1, whatever the select value, and the timeout source is never reported.
- R9: A read that reports transmit-empty clears that source, and the next lower pending source is shown after the read.
- R10: A read does not clear line-error, receive or modem sources. They stay reported while their flags stay high.
- R11: While the read strobe is held, the status byte does not change, whatever the sources do.
- R12: Transmit-empty becomes pending only on a 0-to-1 transition of its flag, and it is dropped when the flag falls. After it has been acknowledged it does not return until the flag falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO mode enable |
| trig_sel | input | 2 | Receive trigger threshold select |
| rx_count | input | 5 | Receive FIFO fill count, 0 to 16 |
| line_err | input | 1 | Receiver line error flag |
| rx_timeout | input | 1 | Receive character timeout flag |
| thr_empty | input | 1 | Transmit holding register empty flag |
| modem_chg | input | 1 | Modem status change flag |
| status_rd | input | 1 | Status register read strobe |
| status | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bound checker checks the following on every cycle: irq agrees with status bit 0, line errors win whenever they are present, the status byte is stable during a held read, timeout never appears in non-FIFO mode, and the FIFO-mode bits follow the enable. The acknowledge-and-reveal sequence of transmit-empty, the edge-only re-arming of transmit-empty, and the full threshold map over every fill count depend on stimulus history. Only the bench's directed sequences and sweeps can show them.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    typedef enum logic [2:0] {
        ID_MODEM  = 3'b000,
        ID_THR    = 3'b001,
        ID_RXDATA = 3'b010,
        ID_LINE   = 3'b011,
        ID_RXTMO  = 3'b110
    } irq_id_e;

    typedef enum logic {
        ST_TRACK = 1'b0,
        ST_READ  = 1'b1
    } rd_state_e;
endpackage

// File: rtl/uirq_trigger.sv
module uirq_trigger #(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL0 = 1,
    parameter int LVL1 = 4,
    parameter int LVL2 = 8,
    parameter int LVL3 = 14,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    output logic             rx_hit
);
    logic [CNT_W-1:0] level_q;
    logic [CNT_W-1:0] level_d;

    always_comb begin
        unique case (trig_sel)
            2'd0: level_d = CNT_W'(LVL0);
            2'd1: level_d = CNT_W'(LVL1);
            2'd2: level_d = CNT_W'(LVL2);
            default: level_d = CNT_W'(LVL3);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= CNT_W'(LVL0);
        else        level_q <= level_d;
    end

    always_comb begin
        if (fifo_en) rx_hit = (rx_count >= level_q);
        else         rx_hit = (rx_count != '0);
    end
endmodule

// File: rtl/uirq_thr_track.sv
module uirq_thr_track (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty,
    input  logic ack,
    output logic pend
);
    logic prev_q;
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= thr_empty;
            if (!thr_empty)      pend_q <= 1'b0;
            else if (!prev_q)    pend_q <= 1'b1;
            else if (ack)        pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
    import uirq_pkg::*;
(
    input  logic    line_err,
    input  logic    rx_hit,
    input  logic    rx_tmo,
    input  logic    thr_pend,
    input  logic    modem_chg,
    output irq_id_e code,
    output logic    pending
);
    always_comb begin
        pending = 1'b1;
        if (line_err)       code = ID_LINE;
        else if (rx_hit)    code = ID_RXDATA;
        else if (rx_tmo)    code = ID_RXTMO;
        else if (thr_pend)  code = ID_THR;
        else if (modem_chg) code = ID_MODEM;
        else begin
            code    = ID_MODEM;
            pending = 1'b0;
        end
    end
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
    import uirq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             line_err,
    input  logic             rx_timeout,
    input  logic             thr_empty,
    input  logic             modem_chg,
    input  logic             status_rd,
    output logic [7:0]       status,
    output logic             irq
);
    rd_state_e state_q, state_d;
    logic [7:0] status_q, status_d;
    logic       irq_q;
    logic       rx_hit, thr_pend, thr_ack, pending;
    irq_id_e    code;
    logic [7:0] live;

    uirq_trigger #(.FIFO_DEPTH(FIFO_DEPTH)) trig_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .trig_sel(trig_sel), .rx_count(rx_count), .rx_hit(rx_hit)
    );

    uirq_thr_track thr_i (
        .clk(clk), .rst_n(rst_n), .thr_empty(thr_empty),
        .ack(thr_ack), .pend(thr_pend)
    );

    uirq_prio_enc enc_i (
        .line_err(line_err), .rx_hit(rx_hit),
        .rx_tmo(rx_timeout & fifo_en), .thr_pend(thr_pend),
        .modem_chg(modem_chg), .code(code), .pending(pending)
    );

    assign live = {fifo_en, fifo_en, 2'b00, code, ~pending};

    // next state
    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        thr_ack  = 1'b0;
        unique case (state_q)
            ST_TRACK: begin
                status_d = live;
                if (status_rd) begin
                    state_d = ST_READ;
                    thr_ack = pending && (code == ID_THR);
                end
            end
            ST_READ: begin
                if (!status_rd) begin
                    state_d  = ST_TRACK;
                    status_d = live;
                end
            end
            default: state_d = ST_TRACK;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 8'h01;
            irq_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            irq_q    <= ~status_d[0];
        end
    end

    assign status = status_q;
    assign irq    = irq_q;
endmodule

// File: rtl/uirq_ident_chk.sv
module uirq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_en,
    input logic       line_err,
    input logic       status_rd,
    input logic [7:0] status,
    input logic       irq
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= 2'd0;
        else if (age_q != 3) age_q <= age_q + 2'd1;
    end

    // R2
    irq_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !status[0]);

    // R3
    line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && !$past(status_rd) && $past(line_err)) |-> status[3:0] == 4'b0110);

    // R11
    read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(status_rd) && $past(status_rd, 2)) |-> $stable(status));

    // R8
    no_tmo_nofifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && !$past(status_rd) && !$past(fifo_en)) |-> status[3:1] != 3'b110);

    // R6
    mode_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && !$past(status_rd)) |-> status[7:4] == {$past(fifo_en), $past(fifo_en), 2'b00});
endmodule

bind uirq_ident uirq_ident_chk chk_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .line_err(line_err),
    .status_rd(status_rd), .status(status), .irq(irq)
);

// File: tb/uirq_ident_tb_top.sv
module uirq_ident_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [1:0] trig_sel = 2'd0;
    logic [4:0] rx_count = 5'd0;
    logic       line_err = 1'b0, rx_timeout = 1'b0, thr_empty = 1'b0;
    logic       modem_chg = 1'b0, status_rd = 1'b0;
    logic [7:0] status;
    logic       irq;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uirq_ident dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .rx_count(rx_count), .line_err(line_err), .rx_timeout(rx_timeout),
        .thr_empty(thr_empty), .modem_chg(modem_chg), .status_rd(status_rd),
        .status(status), .irq(irq)
    );

    function automatic logic [7:0] expect_byte(input logic fe, input logic le,
        input logic rxd, input logic tmo, input logic thr, input logic ms);
        logic [2:0] c;
        logic p;
        p = 1'b1;
        if (le)              c = 3'b011;
        else if (rxd)        c = 3'b010;
        else if (tmo && fe)  c = 3'b110;
        else if (thr)        c = 3'b001;
        else if (ms)         c = 3'b000;
        else begin c = 3'b000; p = 1'b0; end
        return {fe, fe, 2'b00, c, ~p};
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (status !== exp || irq !== ~exp[0]) begin
            errors++;
            $display("FAIL %s status=%h irq=%b expected status=%h irq=%b",
                     req, status, irq, exp, ~exp[0]);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic do_read();
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
        settle();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (2) @(posedge clk);
        #1 check("R1", 8'h01);
        @(negedge clk) rst_n = 1'b1;
        settle();
        check("R1 idle", 8'hC1);

        // R3 R4 R5 R6 R8: sweep all source combinations in both modes
        for (int fe = 0; fe < 2; fe++) begin
            for (int m = 0; m < 32; m++) begin
                @(negedge clk);
                fifo_en = fe[0]; trig_sel = 2'd0;
                thr_empty = 1'b0; line_err = m[0]; rx_count = {4'd0, m[1]};
                rx_timeout = m[2]; modem_chg = m[4];
                settle();
                @(negedge clk) thr_empty = m[3];
                settle();
                check("R3/R4/R5/R6/R8 sweep",
                      expect_byte(fe[0], m[0], m[1], m[2], m[3], m[4]));
            end
        end

        // R7 thresholds with FIFO on; R8 with FIFO off
        @(negedge clk);
        line_err = 0; rx_timeout = 0; thr_empty = 0; modem_chg = 0;
        for (int fe = 0; fe < 2; fe++) begin
            for (int s = 0; s < 4; s++) begin
                for (int n = 0; n <= 16; n++) begin
                    int lvl;
                    logic hit;
                    lvl = (s == 0) ? 1 : (4 << (s - 1)) - ((s == 3) ? 2 : 0);
                    hit = fe[0] ? (n >= lvl) : (n >= 1);
                    @(negedge clk);
                    fifo_en = fe[0]; trig_sel = s[1:0]; rx_count = n[4:0];
                    settle();
                    check(fe[0] ? "R7 threshold" : "R8 nofifo rx",
                          expect_byte(fe[0], 1'b0, hit, 1'b0, 1'b0, 1'b0));
                end
            end
        end

        // R9 R12 transmit-empty acknowledge
        @(negedge clk);
        fifo_en = 1; rx_count = 0; trig_sel = 0; modem_chg = 1; thr_empty = 0;
        settle();
        @(negedge clk) thr_empty = 1;
        settle();
        check("R9 thr shown", 8'hC2);
        do_read();
        check("R9 lower shown", 8'hC0);
        do_read();
        check("R10 modem kept", 8'hC0);
        @(negedge clk) modem_chg = 0;
        settle();
        check("R12 no refire", 8'hC1);
        @(negedge clk) thr_empty = 0;
        settle();
        @(negedge clk) thr_empty = 1;
        settle();
        check("R12 rearm", 8'hC2);
        @(negedge clk) thr_empty = 0;
        settle();
        check("R12 drop on fall", 8'hC1);

        // R10 line error survives read
        @(negedge clk) line_err = 1;
        settle();
        check("R10 line", 8'hC6);
        do_read();
        check("R10 line kept", 8'hC6);

        // R11 frozen during read
        @(negedge clk) status_rd = 1;
        @(negedge clk) begin line_err = 0; modem_chg = 1; end
        repeat (3) @(posedge clk);
        #1 check("R11 frozen", 8'hC6);
        @(negedge clk) status_rd = 0;
        settle();
        check("R11 after", 8'hC0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule